// File: doc/BRIEF.md
# Accumulator Execute Unit

This block is the execute stage of a compact 16-bit accumulator processor. It holds one accumulator and a file of sixteen 16-bit general registers. Each clock it can accept one 8-bit instruction. The upper four bits choose the operation and the lower four bits name the operand register. Every operation involves the accumulator. Bitwise AND, bitwise OR and addition read the operand register and write the accumulator. A store copies the accumulator into the operand register. A left shift moves the operand register up by one bit. When the operand register is register 6, the shift runs across register 4 and register 6 together as one 32-bit word.

The unit finishes each instruction in the clock edge that accepts it, and the program counter then advances by one. The block does not fetch instructions or branch; it only keeps the counter that a fetch stage would use.

A debug port lets a host read any register combinationally and write any register synchronously. If a debug write and an instruction target the same register in the same cycle, the instruction's write is kept.

Top module: `acx_exec`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, the accumulator and all sixteen registers to zero at the next rising edge.
- R2: Major code 0x2 (instr[7:4]) replaces the accumulator with the bitwise AND of the accumulator and register instr[3:0].
- R3: Major code 0x3 replaces the accumulator with the bitwise OR of the accumulator and register instr[3:0].
- R4: Major code 0x4 replaces the accumulator with the low 16 bits of the accumulator plus register instr[3:0]. The carry out is dropped and stored nowhere.
- R5: Major code 0x5 writes the accumulator into register instr[3:0] and leaves the accumulator unchanged.
- R6: Major code 0x6 with operand index other than 6 shifts that register left by one bit and puts zero in bit 0.
- R7: Major code 0x6 with operand index 6 shifts the 32-bit pair {R4, R6} left by one. Old R6 bit 15 becomes R4 bit 0, R6 bit 0 becomes zero, and old R4 bit 15 is lost.
- R8: Each accepted instruction (`instr_valid` high) takes one cycle and adds exactly one to `pc`. Its result is visible at the outputs after that edge. With `instr_valid` low, `pc`, the accumulator and the registers stay as they are, apart from debug writes.
- R9: Any major code outside 0x2 to 0x6 is a no-operation that only adds one to `pc`.
- R10: An instruction changes only its destination (the accumulator, register instr[3:0], and R4 as well for the paired shift) and `pc`.
- R11: `dbg_rdata` shows register `dbg_sel` combinationally. `dbg_we` writes `dbg_wdata` into register `dbg_sel` at the next edge.
- R12: When an instruction and a debug write target the same register in one cycle, the instruction's value is stored. This includes R4 written as the companion of a paired shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction on `instr` is executed this cycle |
| instr | input | 8 | [7:4] major code, [3:0] operand register |
| dbg_sel | input | 4 | Debug register index for read and write |
| dbg_we | input | 1 | Debug write enable |
| dbg_wdata | input | 16 | Debug write data |
| pc | output | 16 | Program counter |
| acc | output | 16 | Accumulator |
| dbg_rdata | output | 16 | Contents of register `dbg_sel` |

## Verification
The checker watches the port-level relations on every cycle: the clearing effect of reset, the one-step counter advance and its hold when idle, the AND result never setting a bit that was clear, the OR result never clearing a bit that was set, and an unchanged accumulator for store, shift and no-operation codes. The exact register contents need the bench's reference model. This covers the wrapped sum, the bit carried from R6 into R4, which operand a store or shift wrote, and which value wins when an instruction and a debug write collide. The bench shows these through the debug read port, in scenario cycles and in full register sweeps.

// File: rtl/acx_pkg.sv
package acx_pkg;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_AND,
        OP_OR,
        OP_ADD,
        OP_STORE,
        OP_SHIFT
    } acx_op_e;

    localparam logic [3:0] OPC_AND   = 4'h2;
    localparam logic [3:0] OPC_OR    = 4'h3;
    localparam logic [3:0] OPC_ADD   = 4'h4;
    localparam logic [3:0] OPC_STORE = 4'h5;
    localparam logic [3:0] OPC_SHIFT = 4'h6;

endpackage

// File: rtl/acx_decode.sv
module acx_decode
    import acx_pkg::*;
#(
    parameter  int SEL_W   = 4,
    localparam int INSTR_W = 4 + SEL_W
) (
    input  logic               valid,
    input  logic [INSTR_W-1:0] instr,
    output acx_op_e            op,
    output logic [SEL_W-1:0]   sel
);

    logic [3:0] major;

    assign major = instr[INSTR_W-1 -: 4];
    assign sel   = instr[SEL_W-1:0];

    always_comb begin
        op = OP_NOP;
        if (valid) begin
            unique case (major)
                OPC_AND:   op = OP_AND;
                OPC_OR:    op = OP_OR;
                OPC_ADD:   op = OP_ADD;
                OPC_STORE: op = OP_STORE;
                OPC_SHIFT: op = OP_SHIFT;
                default:   op = OP_NOP;
            endcase
        end
    end

endmodule

// File: rtl/acx_alu.sv
module acx_alu
    import acx_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SEL_W   = 4,
    parameter int PAIR_LO = 6
) (
    input  acx_op_e           op,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] x_val,
    input  logic [DATA_W-1:0] hi_val,
    output logic              acc_we,
    output logic [DATA_W-1:0] acc_nxt,
    output logic              x_we,
    output logic [DATA_W-1:0] x_nxt,
    output logic              hi_we,
    output logic [DATA_W-1:0] hi_nxt
);

    logic pair;

    assign pair = (sel == SEL_W'(PAIR_LO));

    always_comb begin
        acc_we  = 1'b0;
        acc_nxt = acc;
        x_we    = 1'b0;
        x_nxt   = x_val;
        hi_we   = 1'b0;
        hi_nxt  = hi_val;
        unique case (op)
            OP_AND: begin
                acc_we  = 1'b1;
                acc_nxt = acc & x_val;
            end
            OP_OR: begin
                acc_we  = 1'b1;
                acc_nxt = acc | x_val;
            end
            OP_ADD: begin
                acc_we  = 1'b1;
                acc_nxt = acc + x_val;
            end
            OP_STORE: begin
                x_we  = 1'b1;
                x_nxt = acc;
            end
            OP_SHIFT: begin
                x_we  = 1'b1;
                x_nxt = {x_val[DATA_W-2:0], 1'b0};
                if (pair) begin
                    hi_we  = 1'b1;
                    hi_nxt = {hi_val[DATA_W-2:0], x_val[DATA_W-1]};
                end
            end
            default: begin
                acc_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/acx_regfile.sv
module acx_regfile #(
    parameter  int DATA_W  = 16,
    parameter  int REG_N   = 16,
    parameter  int PAIR_HI = 4,
    localparam int SEL_W   = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pri_we,
    input  logic [SEL_W-1:0]  pri_sel,
    input  logic [DATA_W-1:0] pri_data,
    input  logic              hi_we,
    input  logic [DATA_W-1:0] hi_data,
    input  logic              dbg_we,
    input  logic [SEL_W-1:0]  dbg_sel,
    input  logic [DATA_W-1:0] dbg_wdata,
    input  logic [SEL_W-1:0]  x_sel,
    output logic [DATA_W-1:0] x_rdata,
    output logic [DATA_W-1:0] hi_rdata,
    output logic [DATA_W-1:0] dbg_rdata
);

    logic [DATA_W-1:0] regs   [REG_N];
    logic [REG_N-1:0]  wr_en;
    logic [DATA_W-1:0] wr_val [REG_N];

    // Per-register write selection: instruction, then companion, then debug.
    for (genvar g = 0; g < REG_N; g++) begin : g_port
        logic              we_g;
        logic [DATA_W-1:0] val_g;

        always_comb begin
            if (pri_we && (pri_sel == SEL_W'(g))) begin
                we_g  = 1'b1;
                val_g = pri_data;
            end else if (hi_we && (g == PAIR_HI)) begin
                we_g  = 1'b1;
                val_g = hi_data;
            end else if (dbg_we && (dbg_sel == SEL_W'(g))) begin
                we_g  = 1'b1;
                val_g = dbg_wdata;
            end else begin
                we_g  = 1'b0;
                val_g = regs[g];
            end
        end

        assign wr_en[g]  = we_g;
        assign wr_val[g] = val_g;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_N; i++) begin
                regs[i] <= '0;
            end
        end else begin
            for (int i = 0; i < REG_N; i++) begin
                if (wr_en[i]) begin
                    regs[i] <= wr_val[i];
                end
            end
        end
    end

    assign x_rdata   = regs[x_sel];
    assign hi_rdata  = regs[PAIR_HI];
    assign dbg_rdata = regs[dbg_sel];

endmodule

// File: rtl/acx_exec.sv
module acx_exec
    import acx_pkg::*;
#(
    parameter  int DATA_W  = 16,
    parameter  int REG_N   = 16,
    parameter  int PC_W    = 16,
    parameter  int PAIR_HI = 4,
    parameter  int PAIR_LO = 6,
    localparam int SEL_W   = $clog2(REG_N),
    localparam int INSTR_W = 4 + SEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [SEL_W-1:0]   dbg_sel,
    input  logic               dbg_we,
    input  logic [DATA_W-1:0]  dbg_wdata,
    output logic [PC_W-1:0]    pc,
    output logic [DATA_W-1:0]  acc,
    output logic [DATA_W-1:0]  dbg_rdata
);

    acx_op_e           op;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] x_val;
    logic [DATA_W-1:0] hi_val;
    logic              acc_we;
    logic [DATA_W-1:0] acc_nxt;
    logic              x_we;
    logic [DATA_W-1:0] x_nxt;
    logic              hi_we;
    logic [DATA_W-1:0] hi_nxt;

    acx_decode #(
        .SEL_W (SEL_W)
    ) u_decode (
        .valid (instr_valid),
        .instr (instr),
        .op    (op),
        .sel   (sel)
    );

    acx_alu #(
        .DATA_W  (DATA_W),
        .SEL_W   (SEL_W),
        .PAIR_LO (PAIR_LO)
    ) u_alu (
        .op      (op),
        .sel     (sel),
        .acc     (acc),
        .x_val   (x_val),
        .hi_val  (hi_val),
        .acc_we  (acc_we),
        .acc_nxt (acc_nxt),
        .x_we    (x_we),
        .x_nxt   (x_nxt),
        .hi_we   (hi_we),
        .hi_nxt  (hi_nxt)
    );

    acx_regfile #(
        .DATA_W  (DATA_W),
        .REG_N   (REG_N),
        .PAIR_HI (PAIR_HI)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .pri_we    (x_we),
        .pri_sel   (sel),
        .pri_data  (x_nxt),
        .hi_we     (hi_we),
        .hi_data   (hi_nxt),
        .dbg_we    (dbg_we),
        .dbg_sel   (dbg_sel),
        .dbg_wdata (dbg_wdata),
        .x_sel     (sel),
        .x_rdata   (x_val),
        .hi_rdata  (hi_val),
        .dbg_rdata (dbg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (instr_valid) begin
            pc <= pc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (acc_we) begin
            acc <= acc_nxt;
        end
    end

endmodule

// File: rtl/acx_exec_chk.sv
module acx_exec_chk #(
    parameter int DATA_W  = 16,
    parameter int PC_W    = 16,
    parameter int INSTR_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               instr_valid,
    input logic [INSTR_W-1:0] instr,
    input logic [PC_W-1:0]    pc,
    input logic [DATA_W-1:0]  acc
);

    logic [3:0] major;
    logic       keeps_acc;

    assign major     = instr[INSTR_W-1 -: 4];
    assign keeps_acc = (major == 4'h5) || (major == 4'h6) || (major < 4'h2) || (major > 4'h6);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pc == '0) && (acc == '0));

    a_r8_pc_step: assert property (@(posedge clk) disable iff (rst)
        instr_valid |=> pc == PC_W'($past(pc) + 1'b1));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> $stable(pc) && $stable(acc));

    a_r2_and_never_sets: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && major == 4'h2) |=> (acc & ~$past(acc)) == '0);

    a_r3_or_never_clears: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && major == 4'h3) |=> (acc & $past(acc)) == $past(acc));

    // R5, R9, R10: store, shift and no-operation codes leave the accumulator alone
    a_r10_acc_untouched: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && keeps_acc) |=> $stable(acc));

endmodule

bind acx_exec acx_exec_chk #(
    .DATA_W  (DATA_W),
    .PC_W    (PC_W),
    .INSTR_W (INSTR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr       (instr),
    .pc          (pc),
    .acc         (acc)
);

// File: tb/acx_exec_tb.sv
`timescale 1ns/1ps
module acx_exec_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [7:0]  instr = '0;
    logic [3:0]  dbg_sel = '0;
    logic        dbg_we = 1'b0;
    logic [15:0] dbg_wdata = '0;
    logic [15:0] pc;
    logic [15:0] acc;
    logic [15:0] dbg_rdata;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    logic [15:0] m_r [16];
    logic [15:0] m_a  = '0;
    logic [15:0] m_pc = '0;

    always #2 clk = ~clk;

    acx_exec u_dut (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr       (instr),
        .dbg_sel     (dbg_sel),
        .dbg_we      (dbg_we),
        .dbg_wdata   (dbg_wdata),
        .pc          (pc),
        .acc         (acc),
        .dbg_rdata   (dbg_rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural model of one clock edge.
    task automatic model_step(input logic v, input logic [7:0] ins, input logic dwe,
                              input logic [3:0] ds, input logic [15:0] dwd);
        logic [15:0] old_r [16];
        logic [15:0] old_a;
        int x;
        for (int i = 0; i < 16; i++) old_r[i] = m_r[i];
        old_a = m_a;
        x = int'(ins[3:0]);
        if (dwe) m_r[ds] = dwd;
        if (v) begin
            m_pc = m_pc + 16'd1;
            case (ins[7:4])
                4'h2: m_a = old_a & old_r[x];
                4'h3: m_a = old_a | old_r[x];
                4'h4: m_a = 16'((int'(old_a) + int'(old_r[x])) % 65536);
                4'h5: m_r[x] = old_a;
                4'h6: begin
                    m_r[x] = {old_r[x][14:0], 1'b0};
                    if (x == 6) m_r[4] = {old_r[4][14:0], old_r[6][15]};
                end
                default: ;
            endcase
        end
    endtask

    // Called at a falling edge: drive, take one rising edge, compare at the next falling edge.
    task automatic apply(input logic v, input logic [7:0] ins, input logic dwe,
                         input logic [3:0] ds, input logic [15:0] dwd, input string tag);
        instr_valid = v;
        instr       = ins;
        dbg_we      = dwe;
        dbg_sel     = ds;
        dbg_wdata   = dwd;
        @(posedge clk);
        model_step(v, ins, dwe, ds, dwd);
        @(negedge clk);
        dbg_we = 1'b0;
        check({tag, " pc"}, pc, m_pc);
        check({tag, " acc"}, acc, m_a);
        check({tag, " reg"}, dbg_rdata, m_r[ds]);
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 16; i++) apply(1'b0, 8'h00, 1'b0, 4'(i), 16'h0, tag);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) m_r[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 reset pc", pc, 16'h0);
        check("R1 reset acc", acc, 16'h0);
        rst = 1'b0;
        sweep("R1 reset regs");

        // R11: debug loads
        apply(0, 8'h00, 1, 4'd1,  16'h00F0, "R11 load r1");
        apply(0, 8'h00, 1, 4'd2,  16'h0F0F, "R11 load r2");
        apply(0, 8'h00, 1, 4'd3,  16'hFFFF, "R11 load r3");
        apply(0, 8'h00, 1, 4'd4,  16'h8001, "R11 load r4");
        apply(0, 8'h00, 1, 4'd6,  16'hC003, "R11 load r6");
        apply(0, 8'h00, 1, 4'd7,  16'h8000, "R11 load r7");
        apply(0, 8'h00, 1, 4'd5,  16'h1234, "R11 load r5");
        apply(0, 8'h00, 1, 4'd10, 16'h8000, "R11 load r10");
        check("R11 readback r10", dbg_rdata, 16'h8000);

        apply(1, 8'h31, 0, 4'd0, 16'h0, "R3 or r1");
        check("R3 or literal", acc, 16'h00F0);
        apply(1, 8'h32, 0, 4'd0, 16'h0, "R3 or r2");
        check("R3 or literal 2", acc, 16'h0FFF);
        apply(1, 8'h21, 0, 4'd0, 16'h0, "R2 and r1");
        check("R2 and literal", acc, 16'h00F0);
        apply(1, 8'h43, 0, 4'd0, 16'h0, "R4 add wrap");
        check("R4 add literal", acc, 16'h00EF);
        apply(1, 8'h59, 0, 4'd9, 16'h0, "R5 store r9");
        check("R5 store literal", dbg_rdata, 16'h00EF);
        check("R5 acc kept", acc, 16'h00EF);
        apply(1, 8'h20, 0, 4'd0, 16'h0, "R2 and r0");
        apply(1, 8'h37, 0, 4'd0, 16'h0, "R3 or r7");
        apply(1, 8'h4A, 0, 4'd10, 16'h0, "R4 add carry lost");
        check("R4 carry literal", acc, 16'h0000);
        apply(1, 8'h67, 0, 4'd7, 16'h0, "R6 shift r7");
        check("R6 shift out literal", dbg_rdata, 16'h0000);
        apply(1, 8'h65, 0, 4'd5, 16'h0, "R6 shift r5");
        check("R6 shift literal", dbg_rdata, 16'h2468);
        apply(1, 8'h66, 0, 4'd6, 16'h0, "R7 pair shift r6");
        check("R7 r6 literal", dbg_rdata, 16'h8006);
        apply(0, 8'h00, 0, 4'd4, 16'h0, "R7 pair read r4");
        check("R7 r4 literal", dbg_rdata, 16'h0003);

        apply(1, 8'h00, 0, 4'd0, 16'h0, "R9 nop 0x0");
        apply(1, 8'h1F, 0, 4'd15, 16'h0, "R9 nop 0x1");
        apply(1, 8'h7A, 0, 4'd10, 16'h0, "R9 nop 0x7");
        apply(1, 8'hF6, 0, 4'd6, 16'h0, "R9 nop 0xF");
        apply(0, 8'h31, 0, 4'd1, 16'h0, "R8 idle");
        apply(0, 8'h56, 0, 4'd6, 16'h0, "R8 idle store");
        sweep("R10 after directed");

        apply(1, 8'h31, 0, 4'd0, 16'h0, "R12 prep acc");
        apply(1, 8'h55, 1, 4'd5, 16'hBEEF, "R12 store wins");
        check("R12 store literal", dbg_rdata, 16'h00F0);
        apply(1, 8'h66, 1, 4'd4, 16'hDEAD, "R12 companion wins");
        apply(1, 8'h58, 1, 4'd11, 16'h7777, "R11 write beside store");
        check("R11 side write literal", dbg_rdata, 16'h7777);
        sweep("R12 after collisions");

        for (int k = 0; k < 400; k++) begin
            apply(($urandom % 4) != 0, 8'($urandom), ($urandom % 3) == 0,
                  4'($urandom), 16'($urandom), "R10 random");
        end
        sweep("R10 final sweep");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule